// File: doc/BRIEF.md
# Two-Level Bus Arbiter with Round-Robin Sharing

This block decides which of three masters owns a shared system bus. One parameter selects the variant it builds. The main-bus variant ranks its three masters in a strict fixed order. The peripheral DMA engine (index 0) comes first, the bridge arriving from the Ethernet-side bus (index 1) second, and the processor (index 2) last. The Ethernet-side variant gives the bridge arriving from the main bus (index 0) absolute precedence. Its two Ethernet DMA engines (index 1 = MAC A, index 2 = MAC B) share the level beneath it and take turns by round-robin.

Each master raises its own request bit. The current owner's transfer is framed by a single input that is high during the last cycle of that transfer. Arbitration is pipelined. The next owner is chosen in the cycle that input is high and takes the bus on the following clock edge, so no idle cycle is inserted between owners. An owner is never displaced in the middle of its transfer. When nobody requests, the bus parks on the lowest-ranked master, and that master can start at once.

The outputs are a one-hot grant vector and the binary index of the owner, both driven from registers.

Top module: `dual_bus_arbiter`

## Requirements
- R1: `gnt_o` is always one-hot, and the set bit sits at position `owner_o`. The owner index is a 2-bit binary number, where bit i of `req_i`/`gnt_o` belongs to master i.
- R2: After reset, `owner_o` is 2 and `gnt_o` is 3'b100: the bus is parked, and no transfer is treated as open.
- R3: In main-bus mode (`BUS_KIND` = BUS_MAIN), an arbitration point grants the lowest requesting index: 0 over 1, and 1 over 2.
- R4: In Ethernet-side mode (`BUS_KIND` = BUS_MAC), a request on bit 0 wins every arbitration point. A bridge request that stays high therefore keeps both DMA engines off the bus indefinitely.
- R5: In Ethernet-side mode, when bits 1 and 2 both request and bit 0 does not, the grant goes to the DMA engine that did not win the previous DMA grant. After reset, MAC A (index 1) is served first.
- R6: An arbitration point is a cycle in which no transfer is open or `xfer_last_i` is high. In any other cycle the owner does not change, even if a higher-ranked request is present.
- R7: A winner chosen at an arbitration point becomes the owner on the next clock edge. From then on it holds an open transfer until its `xfer_last_i` cycle.
- R8: At an arbitration point with no request, the bus parks on index 2 and no transfer is open. A request seen in the following cycle is therefore granted at once.
- R9: Grants given to the bridge, and parking, leave the round-robin turn of the DMA engines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Request bit per master (bit i = master i) |
| xfer_last_i | input | 1 | High in the last cycle of the current owner's transfer |
| gnt_o | output | 3 | One-hot grant |
| owner_o | output | 2 | Index of the current owner |

## Verification
Several properties are checked on every cycle:
- the grant stays one-hot;
- the owner is held steady while a transfer is open;
- a bit-0 request always wins an arbitration point;
- an empty arbitration point parks on index 2;
- any other arbitration point hands the bus to a master that was actually requesting.

The round-robin history cannot be seen at the ports in a single cycle, so only the bench scenarios show it. These scenarios cover strict MAC A/MAC B alternation, MAC A being served first after reset, the turn surviving bridge grants, and indefinite starvation of the DMA engines under a bridge request that stays high.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        BUS_MAIN = 1'b0,
        BUS_MAC  = 1'b1
    } bus_kind_e;
endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
module arb_prio_pick #(
    parameter int N = 3,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
// Rotating picker: the search starts just after the last winner.
module arb_rr_pick #(
    parameter int N = 2,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] last_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        int j;
        any_o = 1'b0;
        idx_o = last_i;
        for (int k = 1; k <= N; k++) begin
            j = int'(last_i) + k;
            if (j >= N) j = j - N;
            if (!any_o && req_i[j]) begin
                any_o = 1'b1;
                idx_o = W'(j);
            end
        end
    end
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter
    import arb_pkg::*;
#(
    parameter bus_kind_e BUS_KIND  = BUS_MAC,
    parameter int        N_MASTERS = 3,
    localparam int IDX_W = $clog2(N_MASTERS),
    localparam int LOW_N = N_MASTERS - 1,
    localparam int LOW_W = (LOW_N > 1) ? $clog2(LOW_N) : 1,
    localparam int PARK  = N_MASTERS - 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 xfer_last_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDX_W-1:0]     owner_o
);
    typedef struct packed {
        logic [IDX_W-1:0] owner;
        logic             busy;
        logic [LOW_W-1:0] rr_last;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic             arb_point;
    logic             busy_w;

    generate
        if (BUS_KIND == BUS_MAIN) begin : g_main
            arb_prio_pick #(.N(N_MASTERS)) u_pick (
                .req_i (req_i),
                .any_o (win_any),
                .idx_o (win_idx)
            );
        end else begin : g_mac
            logic             rr_any;
            logic [LOW_W-1:0] rr_idx;
            arb_rr_pick #(.N(LOW_N)) u_rr (
                .req_i  (req_i[N_MASTERS-1:1]),
                .last_i (state_q.rr_last),
                .any_o  (rr_any),
                .idx_o  (rr_idx)
            );
            always_comb begin
                win_any = req_i[0] | rr_any;
                win_idx = req_i[0] ? '0 : (IDX_W'(rr_idx) + IDX_W'(1));
            end
        end
    endgenerate

    assign arb_point = !state_q.busy || xfer_last_i;

    always_comb begin
        state_d = state_q;
        if (arb_point) begin
            if (win_any) begin
                state_d.owner = win_idx;
                state_d.busy  = 1'b1;
                if (BUS_KIND == BUS_MAC && win_idx != '0) begin
                    state_d.rr_last = LOW_W'(win_idx - IDX_W'(1));
                end
            end else begin
                state_d.owner = IDX_W'(PARK);
                state_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.owner   <= IDX_W'(PARK);
            state_q.busy    <= 1'b0;
            state_q.rr_last <= LOW_W'(LOW_N - 1);
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_w  = state_q.busy;
    assign owner_o = state_q.owner;
    assign gnt_o   = N_MASTERS'(1) << state_q.owner;
endmodule

// File: rtl/dual_bus_arbiter_chk.sv
module dual_bus_arbiter_chk #(
    parameter int N = 3,
    localparam int W = $clog2(N)
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [N-1:0] req_i,
    input logic         xfer_last_i,
    input logic [N-1:0] gnt_o,
    input logic [W-1:0] owner_o,
    input logic         busy_i
);
    logic         arb;
    logic [N-1:0] req_q;

    assign arb = !busy_i || xfer_last_i;

    always_ff @(posedge clk_i) req_q <= req_i;

    // R1
    a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gnt_o) == 1);

    // R6
    a_r6_hold_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !xfer_last_i) |=> $stable(owner_o));

    // R3 / R4
    a_r4_top_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb && req_i[0]) |=> (owner_o == '0));

    // R8
    a_r8_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb && req_i == '0) |=> (owner_o == W'(N - 1) && !busy_i));

    // R7
    a_r7_grant_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb && req_i != '0) |=> (busy_i && req_q[owner_o]));
endmodule

bind dual_bus_arbiter dual_bus_arbiter_chk #(.N(N_MASTERS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .xfer_last_i (xfer_last_i),
    .gnt_o       (gnt_o),
    .owner_o     (owner_o),
    .busy_i      (busy_w)
);

// File: tb/test_dual_bus_arbiter.sv
module test_dual_bus_arbiter;
    import arb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_x = '0, req_m = '0;
    logic       last_x = 1'b0, last_m = 1'b0;
    logic [2:0] gnt_x, gnt_m;
    logic [1:0] own_x, own_m;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dual_bus_arbiter #(.BUS_KIND(BUS_MAC)) i_dual_bus_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_x), .xfer_last_i(last_x),
        .gnt_o(gnt_x), .owner_o(own_x)
    );

    dual_bus_arbiter #(.BUS_KIND(BUS_MAIN)) i_dual_bus_arbiter_main (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req_m), .xfer_last_i(last_m),
        .gnt_o(gnt_m), .owner_o(own_m)
    );

    // Reference state per mode (0 = main, 1 = Ethernet side).
    int m_own  [2] = '{2, 2};
    bit m_busy [2] = '{0, 0};
    int m_last [2] = '{2, 2};

    int    exp_q  [$];
    int    mode_q [$];
    string tag_q  [$];

    function automatic int pick(int mode, logic [2:0] r);
        if (r[0]) return 0;
        if (mode == 0) return r[1] ? 1 : 2;
        if (r[1] && r[2]) return (m_last[1] == 1) ? 2 : 1;
        return r[1] ? 1 : 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected owner.
    task automatic step(int mode, logic [2:0] r, logic lst, string tag);
        int w;
        @(negedge clk);
        if (mode == 1) begin req_x = r; last_x = lst; end
        else begin req_m = r; last_m = lst; end
        if (!m_busy[mode] || lst) begin
            if (r == '0) begin
                m_own[mode]  = 2;
                m_busy[mode] = 0;
            end else begin
                w = pick(mode, r);
                m_own[mode]  = w;
                m_busy[mode] = 1;
                if (mode == 1 && w != 0) m_last[1] = w;
            end
        end
        exp_q.push_back(m_own[mode]);
        mode_q.push_back(mode);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                int e, md;
                string t;
                e  = exp_q.pop_front();
                md = mode_q.pop_front();
                t  = tag_q.pop_front();
                if (md == 1) begin
                    check({t, " owner"}, int'(own_x), e);
                    check("R1 grant", int'(gnt_x), 1 << e);
                end else begin
                    check({t, " owner"}, int'(own_m), e);
                    check("R1 grant", int'(gnt_m), 1 << e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset owner mac", int'(own_x), 2);
        check("R2 reset grant mac", int'(gnt_x), 3'b100);
        check("R2 reset owner main", int'(own_m), 2);
        check("R2 reset grant main", int'(gnt_m), 3'b100);

        // Ethernet-side mode
        step(1, 3'b110, 0, "R5 MAC A first");
        step(1, 3'b110, 0, "R6 hold");
        step(1, 3'b111, 0, "R6 bridge waits");
        step(1, 3'b111, 1, "R4 bridge wins");
        for (int i = 0; i < 6; i++) step(1, 3'b111, 1, "R4 starvation");
        step(1, 3'b110, 1, "R9 turn kept");
        for (int i = 0; i < 6; i++) step(1, 3'b110, 1, "R5 alternate");
        step(1, 3'b110, 0, "R7 open transfer");
        step(1, 3'b000, 1, "R8 park");
        step(1, 3'b010, 0, "R8 immediate grant");
        step(1, 3'b100, 1, "R7 handover");
        step(1, 3'b000, 1, "R8 park again");
        step(1, 3'b110, 0, "R9 turn after park");

        // Main-bus mode
        step(0, 3'b111, 0, "R3 top");
        step(0, 3'b110, 1, "R3 middle");
        step(0, 3'b100, 1, "R3 lowest");
        step(0, 3'b011, 1, "R3 top over middle");
        step(0, 3'b010, 0, "R6 hold main");
        step(0, 3'b010, 1, "R3 middle after");
        step(0, 3'b000, 1, "R8 park main");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule